// File: doc/BRIEF.md
# Output Bank Post-Divider with Aligned Restart

This block produces the output clocks of several clock-distribution banks from one source clock. Each bank has a two-bit setting, a select bit and an enable bit, and one mode bit is shared by all banks. Together they pick a divide ratio or a disabled level. The mode bit says which clock feeds the banks: the synthesizer's pre-divider clock (PLL mode) or the reference clock routed around the synthesizer (bypass mode). The clock mux itself sits outside the block. The block runs on a clock at twice the rate of the selected source clock. An output divided by N therefore toggles every N block-clock cycles and has a period of 2N block-clock cycles, and the /1 setting reproduces the source clock.

Once one or more banks have been reprogrammed, their dividers no longer share a phase. A restart request (an active-low pulse on `sync_n`) brings them back into step. Each bank freezes its output at its own low point, and every divider is then held at zero. When the request ends, all banks are released on the same cycle, so their first rising edges coincide. The last bank drives several identical output pairs, and every other bank drives one pair. A status output reports when the banks are known to be running in phase.

Top module: `outbank_postdiv`

## Requirements
- R1: With `pll_mode`=1, a bank with code {sel,en} 2'b01 divides by 2, 2'b10 divides by 8, and 2'b11 passes the clock at /1. A /N output is high for N block-clock cycles and then low for N cycles.
- R2: With `pll_mode`=0, code 2'b01 divides by 4, 2'b10 divides by 16, and 2'b11 passes at /1, with the same duty as in R1.
- R3: Code 2'b00 disables a bank. Its true output is held LOW in PLL mode and HIGH in bypass mode. Every complement output is always the inverse of its true output.
- R4: In reset, every enabled bank output is low. On the first sampled cycle after reset, every enabled bank is high, so all banks start on a common rising edge.
- R5: The last bank drives `WIDE_PAIRS` pairs (bits of `wide_out`), and all of them are identical. Banks 0 to NUM_BANKS-2 drive bits 0 to NUM_BANKS-2 of `narrow_out`.
- R6: `sync_n` passes through a two-flop synchronizer. A low pulse shorter than `MIN_SYNC_CYCLES` block-clock cycles has no effect: outputs keep their phase and `aligned` does not change.
- R7: A qualified low pulse makes each bank stop at a cycle where its divider output is low. While `sync_n` stays low after all banks have stopped, every enabled output is low and `aligned` is 0.
- R8: When `sync_n` returns high, all banks are released on one cycle. In the first cycle that shows `aligned`=1, the enabled outputs are low. From the next cycle on, every bank follows its pattern from phase zero, so all rising edges line up.
- R9: `aligned` is 1 out of reset. It drops in the cycle after any change to `pll_mode`, `bank_sel` or `bank_en`, and while a qualified restart is in progress. It rises on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the selected source clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_mode | input | 1 | 1: PLL ratio table, 0: bypass ratio table |
| bank_sel | input | NUM_BANKS | Select bit per bank |
| bank_en | input | NUM_BANKS | Enable bit per bank |
| sync_n | input | 1 | Asynchronous active-low restart request |
| narrow_out | output | NUM_BANKS-1 | True output of each single-pair bank |
| narrow_out_n | output | NUM_BANKS-1 | Complement outputs of the single-pair banks |
| wide_out | output | WIDE_PAIRS | True outputs of the multi-pair bank |
| wide_out_n | output | WIDE_PAIRS | Complement outputs of the multi-pair bank |
| aligned | output | 1 | High when all banks run from a common phase |

## Verification
The assertions assume that `sync_n` is low for a whole number of block-clock cycles. They also assume that bank settings only change while an output is not being measured, because a setting changed mid-count takes effect at the next reload. The stimulus drives every input at the falling edge and holds each configuration for a full sweep. It drives restart pulses one cycle below the qualifying length and well above it. For the long pulse it keeps `sync_n` low long enough for the slowest divider to reach its low half, so that the hold state is settled before it is observed.

// File: rtl/outbank_pkg.sv
`timescale 1ns/1ps
// Shared constants, state type and ratio decode for the output-bank post-divider.
// Assumes ratios are expressed in block-clock cycles per output half period.
package outbank_pkg;
    localparam int MAX_RATIO  = 16;
    localparam int CNT_W      = $clog2(MAX_RATIO);
    localparam int PLL_LO_DIV = 2;
    localparam int PLL_HI_DIV = 8;
    localparam int BYP_LO_DIV = 4;
    localparam int BYP_HI_DIV = MAX_RATIO;

    typedef enum logic [1:0] {ST_RUN, ST_ARM, ST_HOLD} sync_state_t;

    // True when the bank setting selects the disabled state.
    function automatic logic bank_off(input logic sel, input logic en);
        return !sel && !en;
    endfunction

    // Reload value (ratio minus one) for a bank setting in the given mode.
    function automatic logic [CNT_W-1:0] reload_of(input logic pll, input logic sel, input logic en);
        logic [CNT_W-1:0] r;
        case ({sel, en})
            2'b01:   r = pll ? CNT_W'(PLL_LO_DIV - 1) : CNT_W'(BYP_LO_DIV - 1);
            2'b10:   r = pll ? CNT_W'(PLL_HI_DIV - 1) : CNT_W'(BYP_HI_DIV - 1);
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/outbank_sync_ctrl.sv
`timescale 1ns/1ps
// Restart controller shared by all banks. Synchronizes the active-low request,
// qualifies its length, arms per-bank gating, waits for every bank to stop and
// issues a single release cycle when the request ends.
// Assumes SYNC_STAGES >= 2 and MIN_SYNC_CYCLES >= 1.
module outbank_sync_ctrl
    import outbank_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int MIN_SYNC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic all_gated,
    output logic arm,
    output logic rel,
    output logic busy
);
    localparam int LC_W = $clog2(MIN_SYNC_CYCLES) + 1;
    localparam logic [LC_W-1:0] LC_MAX = LC_W'(MIN_SYNC_CYCLES - 1);

    logic [SYNC_STAGES-1:0] pipe_q;
    logic                   sync_s;
    logic [LC_W-1:0]        low_cnt;
    sync_state_t            state_q, state_d;

    // Bring the asynchronous request into the block clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[SYNC_STAGES-2:0], sync_n};
    end
    assign sync_s = pipe_q[SYNC_STAGES-1];

    // Count consecutive low samples, saturating at the qualifying length.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_s)      low_cnt <= '0;
        else if (low_cnt != LC_MAX) low_cnt <= low_cnt + 1'b1;
    end

    // Next-state decode of the restart sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:  if (!sync_s && low_cnt == LC_MAX) state_d = ST_ARM;
            ST_ARM:  if (all_gated)                    state_d = ST_HOLD;
            ST_HOLD: if (sync_s)                       state_d = ST_RUN;
            default:                                   state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    assign arm  = (state_q == ST_ARM);
    assign rel  = (state_q == ST_HOLD) && sync_s;
    assign busy = (state_q != ST_RUN);

    // R6: arming only follows a request held low for the qualifying length.
    p_arm_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && $past(state_q) == ST_RUN) |-> ($past(!sync_s) && $past(low_cnt) == LC_MAX));

    // R7: hold is entered only once every bank has stopped.
    p_hold_all_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) == ST_ARM) |-> $past(all_gated));

    // R8: a release cycle always returns the sequence to running.
    p_release_to_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> (state_q == ST_RUN));
endmodule

// File: rtl/outbank_divider.sv
`timescale 1ns/1ps
// One bank's post-divider. A down-counter reloads with ratio-1 and toggles the
// output level at zero. When armed, the bank stops at its next low cycle and holds
// its counter and level at zero until released. The disabled level follows the mode.
// Assumes arm and rel come from the shared restart controller.
module outbank_divider
    import outbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pll_mode,
    input  logic sel,
    input  logic en,
    input  logic arm,
    input  logic rel,
    output logic lvl,
    output logic gated
);
    logic [CNT_W-1:0] cnt_q;
    logic             tog_q;
    logic             gated_q;

    // Divider counter, output toggle and per-bank gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tog_q   <= 1'b0;
            gated_q <= 1'b0;
        end else if (rel) begin
            cnt_q   <= '0;
            tog_q   <= 1'b0;
            gated_q <= 1'b0;
        end else if (gated_q) begin
            cnt_q   <= '0;
            tog_q   <= 1'b0;
        end else if (arm && !tog_q) begin
            cnt_q   <= '0;
            gated_q <= 1'b1;
        end else if (cnt_q == '0) begin
            cnt_q   <= reload_of(pll_mode, sel, en);
            tog_q   <= ~tog_q;
        end else begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    // Drive the disabled level or the divided level.
    always_comb begin
        if (bank_off(sel, en)) lvl = !pll_mode;
        else                   lvl = tog_q;
    end
    assign gated = gated_q;

    // R7: a bank stops only while its divided level is low.
    p_gate_at_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gated_q) |-> !$past(tog_q));

    // R7: a stopped bank keeps counter and level at zero.
    p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gated_q |=> (cnt_q == '0 && !tog_q));

    // R1: the level only changes when the counter has run down to zero.
    p_toggle_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!gated_q && !rel && cnt_q != '0) |=> $stable(tog_q));
endmodule

// File: rtl/outbank_postdiv.sv
`timescale 1ns/1ps
// Top of the output-bank post-divider: one divider per bank, a shared restart
// controller, fan-out of the last bank to several pairs, complements, and the
// phase-alignment status. Assumes NUM_BANKS >= 2 and WIDE_PAIRS >= 1.
module outbank_postdiv
    import outbank_pkg::*;
#(
    parameter int NUM_BANKS       = 5,
    parameter int WIDE_PAIRS      = 3,
    parameter int SYNC_STAGES     = 2,
    parameter int MIN_SYNC_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pll_mode,
    input  logic [NUM_BANKS-1:0]  bank_sel,
    input  logic [NUM_BANKS-1:0]  bank_en,
    input  logic                  sync_n,
    output logic [NUM_BANKS-2:0]  narrow_out,
    output logic [NUM_BANKS-2:0]  narrow_out_n,
    output logic [WIDE_PAIRS-1:0] wide_out,
    output logic [WIDE_PAIRS-1:0] wide_out_n,
    output logic                  aligned
);
    localparam int CFG_W = 2 * NUM_BANKS + 1;

    logic [NUM_BANKS-1:0] lvl_vec;
    logic [NUM_BANKS-1:0] gated_vec;
    logic                 arm, rel, busy;
    logic [CFG_W-1:0]     cfg, prev_cfg;
    logic                 cfg_chg;

    outbank_sync_ctrl #(
        .SYNC_STAGES     (SYNC_STAGES),
        .MIN_SYNC_CYCLES (MIN_SYNC_CYCLES)
    ) sync_ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n    (sync_n),
        .all_gated (&gated_vec),
        .arm       (arm),
        .rel       (rel),
        .busy      (busy)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        outbank_divider div_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pll_mode (pll_mode),
            .sel      (bank_sel[b]),
            .en       (bank_en[b]),
            .arm      (arm),
            .rel      (rel),
            .lvl      (lvl_vec[b]),
            .gated    (gated_vec[b])
        );
    end

    assign narrow_out   = lvl_vec[NUM_BANKS-2:0];
    assign narrow_out_n = ~lvl_vec[NUM_BANKS-2:0];

    for (genvar p = 0; p < WIDE_PAIRS; p++) begin : g_wide
        assign wide_out[p]   = lvl_vec[NUM_BANKS-1];
        assign wide_out_n[p] = ~lvl_vec[NUM_BANKS-1];
    end

    assign cfg     = {pll_mode, bank_sel, bank_en};
    assign cfg_chg = (cfg != prev_cfg);

    // Remember the last setting to detect reprogramming.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_cfg <= cfg;
        else        prev_cfg <= cfg;
    end

    // Alignment status: set on release, cleared by reprogramming or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                aligned <= 1'b1;
        else if (rel)              aligned <= 1'b1;
        else if (cfg_chg || busy)  aligned <= 1'b0;
    end

    // R9: release always reports alignment on the next cycle.
    p_release_sets_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> aligned);

    // R9: reprogramming outside a release withdraws alignment.
    p_change_clears_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chg && !rel) |=> !aligned);

    // R8: banks are released only after all of them have stopped.
    p_release_all_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> (&gated_vec));
endmodule

// File: tb/outbank_postdiv_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps all settings in both modes and checks restart behaviour.
module outbank_postdiv_tb_top;
    localparam int NB = 5;
    localparam int WP = 3;
    localparam int MINS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_mode = 1'b1;
    logic [NB-1:0] bank_sel = '0;
    logic [NB-1:0] bank_en = '0;
    logic sync_n = 1'b1;
    logic [NB-2:0] narrow_out, narrow_out_n;
    logic [WP-1:0] wide_out, wide_out_n;
    logic aligned;

    int n_checks = 0;
    int n_fail = 0;
    int t = 0;

    always #4 clk = ~clk;

    outbank_postdiv #(.NUM_BANKS(NB), .WIDE_PAIRS(WP), .SYNC_STAGES(2), .MIN_SYNC_CYCLES(MINS)) dut_i (
        .clk(clk), .rst_n(rst_n), .pll_mode(pll_mode), .bank_sel(bank_sel), .bank_en(bank_en),
        .sync_n(sync_n), .narrow_out(narrow_out), .narrow_out_n(narrow_out_n),
        .wide_out(wide_out), .wide_out_n(wide_out_n), .aligned(aligned));

    function automatic logic exp_lvl(input logic pll, input logic s, input logic e, input int ph);
        int n;
        if (!s && !e) return !pll;
        if (e && !s)      n = pll ? 2 : 4;
        else if (s && !e) n = pll ? 8 : 16;
        else              n = 1;
        return ((ph / n) % 2) == 0;
    endfunction

    function automatic logic bank_lvl(input int b);
        return (b < NB-1) ? narrow_out[b] : wide_out[0];
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b (t=%0d)", tag, act, exp, t);
        end
    endtask

    // Per-bank comparison against the arithmetic model at phase ph.
    task automatic check_banks(input int ph);
        for (int b = 0; b < NB; b++) begin
            string tag;
            if (!bank_sel[b] && !bank_en[b]) tag = "R3 disabled level";
            else if (pll_mode)               tag = "R1 pll ratio";
            else                             tag = "R2 bypass ratio";
            check(bank_lvl(b), exp_lvl(pll_mode, bank_sel[b], bank_en[b], ph), tag);
        end
        check((narrow_out_n == ~narrow_out) && (wide_out_n == ~wide_out), 1'b1, "R3 complement");
        check((wide_out == {WP{1'b1}}) || (wide_out == '0), 1'b1, "R5 wide pairs equal");
    endtask

    // Enabled banks must be low; disabled banks at their mode level.
    task automatic check_all_low(input string tag);
        for (int b = 0; b < NB; b++)
            check(bank_lvl(b), (!bank_sel[b] && !bank_en[b]) ? !pll_mode : 1'b0, tag);
    endtask

    // Sample n cycles; optionally drive a low pulse on sync_n.
    task automatic run_phase(input int n, input int lo_start, input int lo_len, input logic chk_al);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            check_banks(t);
            if (chk_al) check(aligned, 1'b1, "R6 aligned kept");
            t++;
            sync_n = !((i >= lo_start) && (i < lo_start + lo_len));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_all_low("R4 reset outputs");
        check(aligned, 1'b1, "R9 aligned after reset");
        rst_n = 1'b1;
        t = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1 R2 R3 R4 R5: sweep both modes and every code on every bank.
        for (int m = 0; m < 2; m++) begin
            for (int rot = 0; rot < 4; rot++) begin
                pll_mode = m[0];
                for (int b = 0; b < NB; b++) begin
                    int code = (b + rot) % 4;
                    bank_sel[b] = code[1];
                    bank_en[b]  = code[0];
                end
                do_reset();
                run_phase(40, 0, 0, 1'b0);
            end
        end

        // R6: a pulse one cycle short of the qualifying length changes nothing.
        pll_mode = 1'b1;
        bank_sel = 5'b10110;
        bank_en  = 5'b00101;
        do_reset();
        run_phase(40, 10, MINS - 1, 1'b1);
        run_phase(8, 0, 0, 1'b1);

        // R9: reprogramming drops the alignment flag.
        bank_en[1] = 1'b1;
        @(posedge clk); @(negedge clk);
        check(aligned, 1'b0, "R9 aligned cleared by change");

        // R7: long restart request; every bank stopped low.
        sync_n = 1'b0;
        repeat (40) begin @(posedge clk); @(negedge clk); end
        check_all_low("R7 held low");
        check(aligned, 1'b0, "R7 aligned low while held");
        @(posedge clk); @(negedge clk);
        check_all_low("R7 still held");

        // R8: release together, restart from phase zero.
        sync_n = 1'b1;
        begin
            int k = 0;
            while (aligned !== 1'b1 && k < 20) begin
                @(posedge clk); @(negedge clk);
                k++;
            end
            check(aligned, 1'b1, "R8 release reported");
        end
        check_all_low("R8 release cycle low");
        t = 0;
        run_phase(40, 0, 0, 1'b1);

        // R8 in bypass mode with a second release.
        pll_mode = 1'b0;
        bank_sel = 5'b01010;
        bank_en  = 5'b11001;
        @(negedge clk);
        sync_n = 1'b0;
        repeat (40) begin @(posedge clk); @(negedge clk); end
        check_all_low("R7 bypass held low");
        sync_n = 1'b1;
        begin
            int k = 0;
            while (aligned !== 1'b1 && k < 20) begin
                @(posedge clk); @(negedge clk);
                k++;
            end
            check(aligned, 1'b1, "R8 bypass release reported");
        end
        check_all_low("R8 bypass release cycle");
        t = 0;
        run_phase(40, 0, 0, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule